// File: doc/BRIEF.md
# Register-Mapped Interrupt Request Controller

The block collects a set of single-bit interrupt sources into one request line toward a processor. Each source that is seen high latches a sticky request bit. Software can latch bits itself through a set strobe register, remove them through a separate clear strobe register, mask them per source, and read back both the latched set and the masked, pending set. All of this goes through a small synchronous strobe bus.

The processor sees one request output and answers with one acknowledge input. An acknowledge blocks the request line until the pending set has drained to zero. After that, a newly pending source raises the request again. A master enable bit in a control register gates the request as a whole.

Register map (data width 8): 0x1 mask (read/write), 0x2 latched requests (read-only), 0x3 set strobe (write-only), 0x4 clear strobe (write-only), 0x5 pending (read-only), 0x6 control, where bit 0 is the master request enable. Reads of write-only registers and of unmapped addresses return zero.

Top module: `irq_hub`

## Requirements
- R1: A source input that is high at a clock edge sets its bit in the latched request register (address 0x2). The bit stays set after the source returns low.
- R2: A write to address 0x3 ORs the written byte into the latched request register. For example, 0xAA and then 0x55 gives 0xFF. Address 0x3 reads 0x00.
- R3: A write to address 0x4 clears every latched bit that is one in the written byte. For example, 0xFF, then a clear of 0x71, gives 0x8E, and a further clear of 0x85 gives 0x0A. Address 0x4 reads 0x00.
- R4: When a source is high in the same cycle as a clear write of its bit, the bit stays set.
- R5: The mask register at 0x1 reads back what was written. The pending register at 0x5 equals the latched bits ANDed with the mask, registered one clock later.
- R6: The request output is high exactly when some pending bit is set, bit 0 of the control register (0x6) is one, and the allow flag is set.
- R7: An acknowledge pulse clears the allow flag, so the request output drops even while bits are still pending. The flag is set again only once the pending register is all zero, and a later pending bit then raises the request.
- R8: After reset the request output is low, the read data is 0x00, and every register reads 0x00.
- R9: Read data and a one-cycle ready pulse appear one clock after a read strobe. Ready is high in the same cycle as a write strobe. Addresses 0x0 and 0x7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_i | input | 1 | Bus chip select |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, held until the next read |
| rdy_o | output | 1 | Access complete |
| src_i | input | 8 | Interrupt sources, active high |
| ack_i | input | 1 | Acknowledge from the processor |
| irq_o | output | 1 | Request to the processor |

## Verification
The assertions assume that the sources and bus strobes are synchronous to the clock. They also assume that read and write strobes are never raised together, and that the acknowledge is a single-cycle pulse. The bench drives every input on the falling edge and only one operation at a time, whether random or directed. It then lets three idle cycles pass so that the pending register and allow flag settle before it reads anything back. The set-versus-clear collision is the only case where the bench drives a source and a bus write in the same cycle, and it does so on purpose.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int unsigned SEL_MASK    = 1;
  localparam int unsigned SEL_LATCH   = 2;
  localparam int unsigned SEL_SET     = 3;
  localparam int unsigned SEL_CLR     = 4;
  localparam int unsigned SEL_PENDING = 5;
  localparam int unsigned SEL_CTRL    = 6;
endpackage

// File: rtl/irq_hub_regif.sv
module irq_hub_regif
  import irq_hub_pkg::*;
#(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [WIDTH-1:0]  latch_i,
  input  logic [WIDTH-1:0]  pend_i,
  output logic [WIDTH-1:0]  mask_o,
  output logic              en_o,
  output logic [WIDTH-1:0]  set_o,
  output logic [WIDTH-1:0]  clr_o,
  output logic [WIDTH-1:0]  rdata_o,
  output logic              rdy_o
);
  logic             wr_acc, rd_acc;
  logic [WIDTH-1:0] mask_q, mask_d;
  logic             en_q, en_d;
  logic [WIDTH-1:0] rdata_q, rdata_d, rd_mux;
  logic             rdy_q, rdy_d;

  assign wr_acc = cs_i & wr_i;
  assign rd_acc = cs_i & rd_i;

  always_comb begin
    mask_d  = mask_q;
    en_d    = en_q;
    set_o   = '0;
    clr_o   = '0;
    if (wr_acc) begin
      if (addr_i == ADDR_W'(SEL_MASK)) mask_d = wdata_i;
      if (addr_i == ADDR_W'(SEL_CTRL)) en_d = wdata_i[0];
      if (addr_i == ADDR_W'(SEL_SET))  set_o = wdata_i;
      if (addr_i == ADDR_W'(SEL_CLR))  clr_o = wdata_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_W'(SEL_MASK))    rd_mux = mask_q;
    if (addr_i == ADDR_W'(SEL_LATCH))   rd_mux = latch_i;
    if (addr_i == ADDR_W'(SEL_PENDING)) rd_mux = pend_i;
    if (addr_i == ADDR_W'(SEL_CTRL))    rd_mux = WIDTH'(en_q);
    rdata_d = rd_acc ? rd_mux : rdata_q;
    rdy_d   = rd_acc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      en_q    <= 1'b0;
      rdata_q <= '0;
      rdy_q   <= 1'b0;
    end else begin
      mask_q  <= mask_d;
      en_q    <= en_d;
      rdata_q <= rdata_d;
      rdy_q   <= rdy_d;
    end
  end

  assign mask_o  = mask_q;
  assign en_o    = en_q;
  assign rdata_o = rdata_q;
  assign rdy_o   = rdy_q | wr_acc;

  assert_read_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i) |=> rdy_o);
  assert_clr_reads_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && addr_i == ADDR_W'(SEL_CLR)) |=> (rdata_o == '0));
  assert_mask_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && addr_i == ADDR_W'(SEL_MASK)) |=> (mask_o == $past(wdata_i)));
endmodule

// File: rtl/irq_hub_store.sv
module irq_hub_store #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] src_i,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic [WIDTH-1:0] latch_o,
  output logic [WIDTH-1:0] pend_o
);
  logic [WIDTH-1:0] latch_q, latch_d;
  logic [WIDTH-1:0] pend_q, pend_d;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      latch_d[i] = src_i[i] | set_i[i] | (latch_q[i] & ~clr_i[i]);
      pend_d[i]  = latch_q[i] & mask_i[i];
    end

    assert_src_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src_i[i] |=> latch_o[i]);
    assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_i[i] && clr_i[i]) |=> latch_o[i]);
    assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !src_i[i] && !set_i[i]) |=> !latch_o[i]);
    assert_pend_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (latch_o[i] && mask_i[i]) |=> pend_o[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      pend_q  <= '0;
    end else begin
      latch_q <= latch_d;
      pend_q  <= pend_d;
    end
  end

  assign latch_o = latch_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/irq_hub_gate.sv
module irq_hub_gate #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pend_i,
  input  logic             en_i,
  input  logic             ack_i,
  output logic             irq_o
);
  logic allow_q, allow_d;

  always_comb begin
    allow_d = allow_q;
    if (ack_i)               allow_d = 1'b0;
    else if (pend_i == '0)   allow_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) allow_q <= 1'b0;
    else         allow_q <= allow_d;
  end

  assign irq_o = (|pend_i) & en_i & allow_q;

  assert_ack_drops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !irq_o);
  assert_no_rearm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !ack_i && (pend_i != '0) && $stable(pend_i) && $stable(en_i) && en_i)
      |=> !irq_o);
endmodule

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  output logic              rdy_o,
  input  logic [WIDTH-1:0]  src_i,
  input  logic              ack_i,
  output logic              irq_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [WIDTH-1:0] mask, set_m, clr_m, latch, pend;
  logic             en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  irq_hub_regif #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) i_regif (
    .clk_i(clk_i), .rst_ni(rst_int_n), .cs_i(cs_i), .addr_i(addr_i),
    .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i), .latch_i(latch),
    .pend_i(pend), .mask_o(mask), .en_o(en), .set_o(set_m), .clr_o(clr_m),
    .rdata_o(rdata_o), .rdy_o(rdy_o)
  );

  irq_hub_store #(.WIDTH(WIDTH)) i_store (
    .clk_i(clk_i), .rst_ni(rst_int_n), .src_i(src_i), .set_i(set_m),
    .clr_i(clr_m), .mask_i(mask), .latch_o(latch), .pend_o(pend)
  );

  irq_hub_gate #(.WIDTH(WIDTH)) i_gate (
    .clk_i(clk_i), .rst_ni(rst_int_n), .pend_i(pend), .en_i(en),
    .ack_i(ack_i), .irq_o(irq_o)
  );

  assert_reset_quiet_R8: assert property (@(posedge clk_i)
    (!rst_int_n) |-> (!irq_o && rdata_o == '0));
endmodule

// File: tb/test_irq_hub.sv
module test_irq_hub;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs, wr, rd, ack;
  logic [2:0] addr;
  logic [7:0] wdata, rdata, src;
  logic       rdy, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_irr, m_ier;
  logic       m_en, m_allow;

  always #10 clk = ~clk;

  irq_hub i_irq_hub (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .addr_i(addr), .wr_i(wr),
    .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .rdy_o(rdy),
    .src_i(src), .ack_i(ack), .irq_o(irq)
  );

  function automatic logic exp_irq();
    return (|(m_irr & m_ier)) & m_en & m_allow;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    if ((m_irr & m_ier) == 8'h00) m_allow = 1'b1;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0;
    case (a)
      3'd1: m_ier = d;
      3'd3: m_irr = m_irr | d;
      3'd4: m_irr = m_irr & ~d;
      3'd6: m_en  = d[0];
      default: ;
    endcase
    settle();
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1; rd = 1; addr = a;
    @(negedge clk);
    d = rdata;
    chk("R9 read ready", {7'd0, rdy}, 8'h01);
    cs = 0; rd = 0;
  endtask

  task automatic chk_reg(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    bus_read(a, v);
    chk(tag, v, exp);
  endtask

  task automatic pulse_src(input logic [7:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
    src = 0;
    m_irr = m_irr | v;
    settle();
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    ack = 1;
    @(negedge clk);
    ack = 0;
    m_allow = 1'b0;
    settle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5eed_1234));
    rst_n = 0; cs = 0; wr = 0; rd = 0; ack = 0; addr = 0; wdata = 0; src = 0;
    m_irr = 0; m_ier = 0; m_en = 0; m_allow = 1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R8 reset state
    chk("R8 irq after reset", {7'd0, irq}, 8'h00);
    chk("R8 rdata after reset", rdata, 8'h00);
    for (int a = 1; a < 7; a++) chk_reg("R8 register default", 3'(a), 8'h00);

    // R9 write ready in same cycle
    @(negedge clk);
    cs = 1; wr = 1; addr = 3'd1; wdata = 8'h0F;
    #1 chk("R9 write ready", {7'd0, rdy}, 8'h01);
    @(negedge clk);
    cs = 0; wr = 0; m_ier = 8'h0F;
    settle();
    chk_reg("R5 mask readback", 3'd1, 8'h0F);
    bus_write(3'd1, 8'h00);

    // R2 / R3 directed sequence
    bus_write(3'd3, 8'hAA); chk_reg("R2 set 0xAA", 3'd2, 8'hAA);
    bus_write(3'd3, 8'h55); chk_reg("R2 set 0x55", 3'd2, 8'hFF);
    chk_reg("R2 set reg reads zero", 3'd3, 8'h00);
    bus_write(3'd4, 8'h71); chk_reg("R3 clear 0x71", 3'd2, 8'h8E);
    bus_write(3'd4, 8'h85); chk_reg("R3 clear 0x85", 3'd2, 8'h0A);
    chk_reg("R3 clear reg reads zero", 3'd4, 8'h00);
    chk_reg("R9 unmapped 0", 3'd0, 8'h00);
    chk_reg("R9 unmapped 7", 3'd7, 8'h00);
    bus_write(3'd4, 8'hFF);

    // R1 sticky source
    pulse_src(8'h10);
    chk_reg("R1 sticky after source low", 3'd2, 8'h10);

    // R4 set wins over clear
    @(negedge clk);
    src = 8'h01; cs = 1; wr = 1; addr = 3'd4; wdata = 8'h11;
    @(negedge clk);
    src = 0; cs = 0; wr = 0;
    m_irr = 8'h01;
    settle();
    chk_reg("R4 set wins", 3'd2, 8'h01);

    // R5 / R6 gating
    bus_write(3'd1, 8'h01);
    chk_reg("R5 pending", 3'd5, 8'h01);
    chk("R6 irq held off by enable", {7'd0, irq}, 8'h00);
    bus_write(3'd6, 8'h01);
    chk_reg("R6 control readback", 3'd6, 8'h01);
    chk("R6 irq asserted", {7'd0, irq}, 8'h01);

    // R7 acknowledge and rearm
    pulse_ack();
    chk("R7 irq low after ack", {7'd0, irq}, 8'h00);
    chk_reg("R7 still pending", 3'd5, 8'h01);
    bus_write(3'd3, 8'h02); bus_write(3'd1, 8'h03);
    chk("R7 no rearm while pending", {7'd0, irq}, 8'h00);
    bus_write(3'd4, 8'h03);
    chk("R7 low when drained", {7'd0, irq}, 8'h00);
    bus_write(3'd3, 8'h02);
    chk("R7 reasserted after rearm", {7'd0, irq}, 8'h01);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: bus_write(3'd1, 8'($urandom));
        1: bus_write(3'd3, 8'($urandom) & 8'($urandom));
        2: bus_write(3'd4, 8'($urandom));
        3: bus_write(3'd6, 8'($urandom_range(0, 3)));
        4: pulse_src(8'(1 << $urandom_range(0, 7)));
        default: pulse_ack();
      endcase
      chk_reg("R1 R2 R3 random latched", 3'd2, m_irr);
      chk_reg("R5 random pending", 3'd5, m_irr & m_ier);
      chk("R6 R7 random irq", {7'd0, irq}, {7'd0, exp_irq()});
    end
    finish_run();
  end
endmodule